// File: doc/BRIEF.md
# Quad DAC Command Decoder and Register Bank

This block is the digital core of a four-channel, 12-bit converter that is programmed over a serial link. A front end outside this block collects a 16-bit command word. It presents the word together with a one-cycle strobe when chip select rises. The block splits the word into a channel address, a control code and a data field, and acts on it. Each channel is double-buffered: an input register sits in front of a DAC register, and only the DAC register drives the converter code.

The address and control fields together select one of sixteen commands. These cover the following actions:
- load one input register only
- load one input register and then update every DAC register
- copy all input registers into the DAC registers
- broadcast one value into every register
- drive a general-purpose output pin high or low
- choose the clock edge that the serial-out shifter uses
- enter a low-power sleep, which an active-low lockout pin can veto

A falling lockout pin wakes the block from sleep, and any command that writes the DAC registers also wakes it. A synchronous active-low clear returns everything to the power-up state. The DAC codes keep their values through sleep, so waking restores the earlier outputs.

Top module: `qdac_ctrl_core`

## Requirements
- R1: The word is laid out as address[15:14], control[13:12], data[11:0]. Address 0..3 selects channels A..D, and channel i's code appears on dac_codes[12*i+11:12*i].
- R2: Control 01 loads the data into the addressed input register and leaves every DAC code unchanged.
- R3: Control 11 loads the addressed input register and then copies all four input registers, including the new value, into the DAC registers.
- R4: Full code 0100 (address 01, control 00) copies every input register into its DAC register.
- R5: Full code 1000 writes the data into all input and all DAC registers.
- R6: Full code 1100 sets asleep only if sleep_block_n is high. During sleep the DAC codes and input registers keep their values and commands are still accepted.
- R7: Full code 0010 drives user_out low and full code 0110 drives it high.
- R8: Full code 0000 changes no code, user_out, edge mode or sleep state.
- R9: Full code 1110 sets dout_on_rise to 1 and full code 1010 sets it to 0. Both also copy all input registers into the DAC registers.
- R10: A high-to-low change on sleep_block_n while asleep clears asleep, and the DAC codes stay as they were before sleep.
- R11: Codes 0100, 1000, 1110, 1010 and any control-11 command clear asleep.
- R12: Reset, or clr_n low at a clock edge, zeroes all input and DAC registers, drives user_out low, sets dout_on_rise to 0 and clears asleep.
- R13: A command is visible on the outputs after the clock edge that samples cmd_stb high and not before. A strobe sampled while clr_n is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cmd_word | input | 16 | Completed command word |
| cmd_stb | input | 1 | One-cycle strobe: cmd_word is complete |
| clr_n | input | 1 | Synchronous active-low clear of all state |
| sleep_block_n | input | 1 | Low vetoes sleep; a falling edge wakes |
| dac_codes | output | 48 | Four 12-bit DAC register values, channel A lowest |
| asleep | output | 1 | Sleep state flag |
| user_out | output | 1 | General-purpose output level |
| dout_on_rise | output | 1 | 1 when serial-out shifts on the rising edge |

## Verification
The assertions assume a few things about the inputs. cmd_word is valid whenever cmd_stb is sampled high, and the strobe lasts a single clock per command. sleep_block_n changes only between edges, and its falling edge is seen by the same clock that samples the block's state. The bench follows these rules by driving every input on the falling clock edge and by pulsing the strobe for exactly one cycle. Lockout changes are never made in the same cycle as a strobe, except where the test checks that a vetoed sleep command is dropped.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  parameter int unsigned QDAC_CH = 4;
  parameter int unsigned QDAC_DW = 12;

  typedef enum logic [1:0] {
    CC_MISC   = 2'b00,
    CC_LDIN   = 2'b01,
    CC_CONFIG = 2'b10,
    CC_LDUPD  = 2'b11
  } ctrl_code_e;

  typedef struct packed {
    logic ld_one;
    logic ld_bcast;
    logic xfer;
    logic sleep;
    logic upo_wr;
    logic upo_val;
    logic mode_wr;
    logic mode_val;
    logic wake;
  } qdac_act_t;
endpackage

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
  import qdac_pkg::*;
#(
  parameter int unsigned CH_N = QDAC_CH,
  parameter int unsigned DW   = QDAC_DW,
  localparam int unsigned AW  = $clog2(CH_N),
  localparam int unsigned WW  = AW + 2 + DW
) (
  input  logic [WW-1:0] word,
  input  logic          stb,
  input  logic          clr_n,
  input  logic          sleep_block_n,
  output qdac_act_t     act,
  output logic [AW-1:0] sel,
  output logic [DW-1:0] data
);
  ctrl_code_e ctrl;
  logic       live;

  assign sel  = word[WW-1 -: AW];
  assign ctrl = ctrl_code_e'(word[DW+1:DW]);
  assign data = word[DW-1:0];
  assign live = stb && clr_n;

  always_comb begin
    act = '0;
    if (live) begin
      unique case (ctrl)
        CC_LDIN: act.ld_one = 1'b1;
        CC_LDUPD: begin
          act.ld_one = 1'b1;
          act.xfer   = 1'b1;
          act.wake   = 1'b1;
        end
        CC_MISC: begin
          if (sel == AW'(1)) begin
            act.xfer = 1'b1;
            act.wake = 1'b1;
          end else if (sel == AW'(2)) begin
            act.ld_bcast = 1'b1;
            act.wake     = 1'b1;
          end else if (sel == AW'(3)) begin
            act.sleep = sleep_block_n;
          end
        end
        CC_CONFIG: begin
          if (sel == AW'(0) || sel == AW'(1)) begin
            act.upo_wr  = 1'b1;
            act.upo_val = sel[0];
          end else if (sel == AW'(2) || sel == AW'(3)) begin
            act.mode_wr  = 1'b1;
            act.mode_val = sel[0];
            act.xfer     = 1'b1;
            act.wake     = 1'b1;
          end
        end
        default: act = '0;
      endcase
    end
  end
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
  import qdac_pkg::*;
#(
  parameter int unsigned CH_N = QDAC_CH,
  parameter int unsigned DW   = QDAC_DW,
  localparam int unsigned AW  = $clog2(CH_N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_n,
  input  qdac_act_t          act,
  input  logic [AW-1:0]      sel,
  input  logic [DW-1:0]      data,
  output logic [CH_N*DW-1:0] codes
);
  for (genvar i = 0; i < CH_N; i++) begin : g_lane
    logic [DW-1:0] in_q, in_d, dac_q;

    always_comb begin
      in_d = in_q;
      if (act.ld_bcast) in_d = data;
      else if (act.ld_one && sel == AW'(i)) in_d = data;
    end

    always_ff @(posedge clk) begin
      if (rst || !clr_n) begin
        in_q  <= '0;
        dac_q <= '0;
      end else begin
        in_q <= in_d;
        if (act.ld_bcast) dac_q <= data;
        else if (act.xfer) dac_q <= in_d;
      end
    end

    assign codes[i*DW +: DW] = dac_q;

    a_r5_bcast_lane: assert property (@(posedge clk) disable iff (rst)
      (act.ld_bcast && clr_n) |=> (codes[i*DW +: DW] == $past(data)));
  end
endmodule

// File: rtl/qdac_ctl_state.sv
module qdac_ctl_state
  import qdac_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr_n,
  input  logic      sleep_block_n,
  input  qdac_act_t act,
  output logic      asleep,
  output logic      user_out,
  output logic      dout_on_rise
);
  logic lock_prev;
  logic lock_fall;

  assign lock_fall = lock_prev && !sleep_block_n;

  always_ff @(posedge clk) begin
    if (rst) lock_prev <= 1'b1;
    else     lock_prev <= sleep_block_n;
  end

  always_ff @(posedge clk) begin
    if (rst || !clr_n) begin
      asleep       <= 1'b0;
      user_out     <= 1'b0;
      dout_on_rise <= 1'b0;
    end else begin
      if (act.upo_wr)  user_out     <= act.upo_val;
      if (act.mode_wr) dout_on_rise <= act.mode_val;
      if (act.sleep)                     asleep <= 1'b1;
      else if (act.wake || lock_fall)    asleep <= 1'b0;
    end
  end

  a_r6_sleep_needs_unblock: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> $past(sleep_block_n));

  a_r10_fall_wakes: assert property (@(posedge clk) disable iff (rst)
    (asleep && $fell(sleep_block_n)) |=> !asleep);

  a_r11_cmd_wakes: assert property (@(posedge clk) disable iff (rst)
    (act.wake && clr_n) |=> !asleep);
endmodule

// File: rtl/qdac_ctrl_core.sv
module qdac_ctrl_core
  import qdac_pkg::*;
#(
  parameter int unsigned CH_N = QDAC_CH,
  parameter int unsigned DW   = QDAC_DW,
  localparam int unsigned AW  = $clog2(CH_N),
  localparam int unsigned WW  = AW + 2 + DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WW-1:0]      cmd_word,
  input  logic               cmd_stb,
  input  logic               clr_n,
  input  logic               sleep_block_n,
  output logic [CH_N*DW-1:0] dac_codes,
  output logic               asleep,
  output logic               user_out,
  output logic               dout_on_rise
);
  qdac_act_t     act;
  logic [AW-1:0] sel;
  logic [DW-1:0] data;

  qdac_cmd_decode #(.CH_N(CH_N), .DW(DW)) u_dec (
    .word(cmd_word), .stb(cmd_stb), .clr_n(clr_n),
    .sleep_block_n(sleep_block_n), .act(act), .sel(sel), .data(data)
  );

  qdac_chan_bank #(.CH_N(CH_N), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .clr_n(clr_n), .act(act), .sel(sel),
    .data(data), .codes(dac_codes)
  );

  qdac_ctl_state u_state (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sleep_block_n(sleep_block_n),
    .act(act), .asleep(asleep), .user_out(user_out),
    .dout_on_rise(dout_on_rise)
  );

  a_r2_buffered_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && clr_n && cmd_word[DW+1:DW] == 2'b01) |=> $stable(dac_codes));

  a_r8_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && clr_n && cmd_word[WW-1:DW] == '0) |=>
      ($stable(dac_codes) && $stable(user_out) &&
       $stable(dout_on_rise) && $stable(asleep)));

  a_r12_clear_state: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (dac_codes == '0 && !user_out && !dout_on_rise && !asleep));

  a_r13_no_strobe_no_change: assert property (@(posedge clk) disable iff (rst)
    (!cmd_stb && clr_n && sleep_block_n) |=>
      ($stable(dac_codes) && $stable(user_out) && $stable(dout_on_rise)));
endmodule

// File: tb/sim_qdac_ctrl_core.sv
module sim_qdac_ctrl_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cmd_word = '0;
  logic        cmd_stb = 1'b0;
  logic        clr_n = 1'b1;
  logic        sleep_block_n = 1'b1;
  logic [47:0] dac_codes;
  logic        asleep, user_out, dout_on_rise;

  int total = 0;
  int bad = 0;

  logic [11:0] m_in  [4];
  logic [11:0] m_dac [4];
  logic        m_upo, m_mode, m_pd;

  always #2 clk = ~clk;

  qdac_ctrl_core u0 (
    .clk(clk), .rst(rst), .cmd_word(cmd_word), .cmd_stb(cmd_stb),
    .clr_n(clr_n), .sleep_block_n(sleep_block_n), .dac_codes(dac_codes),
    .asleep(asleep), .user_out(user_out), .dout_on_rise(dout_on_rise)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_codes();
    return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " codes"}, dac_codes, exp_codes());
    chk({tag, " upo"}, 48'(user_out), 48'(m_upo));
    chk({tag, " mode"}, 48'(dout_on_rise), 48'(m_mode));
    chk({tag, " asleep"}, 48'(asleep), 48'(m_pd));
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    m_upo = 1'b0; m_mode = 1'b0; m_pd = 1'b0;
  endtask

  task automatic model_xfer();
    for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    m_pd = 1'b0;
  endtask

  task automatic model_cmd(input logic [15:0] w);
    logic [1:0] a, c;
    a = w[15:14]; c = w[13:12];
    case (c)
      2'b01: m_in[a] = w[11:0];
      2'b11: begin m_in[a] = w[11:0]; model_xfer(); end
      2'b00: case (a)
        2'd1: model_xfer();
        2'd2: begin
          for (int i = 0; i < 4; i++) begin m_in[i] = w[11:0]; m_dac[i] = w[11:0]; end
          m_pd = 1'b0;
        end
        2'd3: if (sleep_block_n) m_pd = 1'b1;
        default: ;
      endcase
      default: case (a)
        2'd0: m_upo = 1'b0;
        2'd1: m_upo = 1'b1;
        2'd2: begin m_mode = 1'b0; model_xfer(); end
        default: begin m_mode = 1'b1; model_xfer(); end
      endcase
    endcase
  endtask

  task automatic send(input logic [1:0] a, input logic [1:0] c, input logic [11:0] d);
    @(negedge clk);
    cmd_word = {a, c, d};
    cmd_stb  = 1'b1;
    if (clr_n) model_cmd({a, c, d});
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic t_reset();
    model_clear();
    check_all("R12 reset");
  endtask

  task automatic t_buffered();
    for (int i = 0; i < 4; i++) send(2'(i), 2'b01, 12'h100 + 12'(i * 17));
    check_all("R2 input-only load");
    send(2'd1, 2'b00, 12'hFFF);
    check_all("R4 transfer all");
    chk("R1 channel C slot", 48'(dac_codes[35:24]), 48'h122);
  endtask

  task automatic t_load_upd();
    send(2'd0, 2'b01, 12'h111);
    send(2'd2, 2'b11, 12'hABC);
    check_all("R3 load and update");
    chk("R3 channel A from input", 48'(dac_codes[11:0]), 48'h111);
  endtask

  task automatic t_bcast();
    send(2'd2, 2'b00, 12'h5A5);
    check_all("R5 broadcast");
    send(2'd1, 2'b00, 12'h000);
    check_all("R5 input regs also broadcast");
  endtask

  task automatic t_upo_nop();
    send(2'd1, 2'b10, 12'h000);
    check_all("R7 upo high");
    send(2'd0, 2'b00, 12'hFFF);
    check_all("R8 nop");
    send(2'd0, 2'b10, 12'h000);
    check_all("R7 upo low");
  endtask

  task automatic t_mode();
    send(2'd1, 2'b01, 12'h777);
    send(2'd3, 2'b10, 12'h000);
    check_all("R9 mode rising + transfer");
    send(2'd3, 2'b01, 12'h0C3);
    send(2'd2, 2'b10, 12'h000);
    check_all("R9 mode falling + transfer");
  endtask

  task automatic t_sleep();
    @(negedge clk); sleep_block_n = 1'b0;
    send(2'd3, 2'b00, 12'h000);
    check_all("R6 sleep vetoed");
    @(negedge clk); sleep_block_n = 1'b1;
    send(2'd3, 2'b00, 12'h000);
    check_all("R6 sleep entered");
    send(2'd3, 2'b01, 12'h9E1);
    check_all("R6 input load during sleep");
    @(negedge clk); sleep_block_n = 1'b0;
    @(negedge clk); m_pd = 1'b0;
    check_all("R10 lockout fall wakes");
    send(2'd1, 2'b00, 12'h000);
    check_all("R6 input kept through sleep");
    @(negedge clk); sleep_block_n = 1'b1;
  endtask

  task automatic t_wake_cmd();
    send(2'd3, 2'b00, 12'h000);
    check_all("R11 sleep again");
    send(2'd0, 2'b11, 12'h321);
    check_all("R11 load-update wakes");
    send(2'd3, 2'b00, 12'h000);
    send(2'd2, 2'b00, 12'h0F0);
    check_all("R11 broadcast wakes");
  endtask

  task automatic t_timing_clear();
    @(negedge clk);
    cmd_word = {2'd2, 2'b00, 12'hEEE};
    cmd_stb  = 1'b1;
    #1;
    check_all("R13 no change before edge");
    model_cmd({2'd2, 2'b00, 12'hEEE});
    @(negedge clk); cmd_stb = 1'b0;
    check_all("R13 change after edge");
    send(2'd1, 2'b10, 12'h000);
    @(negedge clk); clr_n = 1'b0;
    cmd_word = {2'd2, 2'b00, 12'h333};
    cmd_stb  = 1'b1;
    @(negedge clk); cmd_stb = 1'b0; clr_n = 1'b1;
    model_clear();
    check_all("R12 clear and R13 strobe ignored");
    send(2'd1, 2'b00, 12'h000);
    check_all("R12 inputs cleared");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_buffered();
    t_load_upd();
    t_bcast();
    t_upo_nop();
    t_mode();
    t_sleep();
    t_wake_cmd();
    t_timing_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule